// File: doc/BRIEF.md
# NAND Read Prefetch Engine

This block moves a programmed number of bytes from an 8-bit NAND data port into a small on-chip byte FIFO, so that a host can collect them later as 32-bit words. Software loads a byte count and a configuration word, then writes the run bit of the control register. From then on the engine takes one byte per cycle from the NAND port, but only while the FIFO has room and the flash reports ready. The host watches the status register or the availability output and pops whole words.

A run ends by itself once every programmed byte has been fetched and handed to the host. Software can also cancel a run at any time by writing zero to control, which flushes the FIFO. While a run is in progress the engine refuses any new configuration and any second start. The FIFO threshold field sets how full the FIFO must be before the availability output tells the host to come and drain it.

Top module: `nand_prefetch`

## Requirements
- R1: After reset, every register reads zero, no NAND byte is requested, and host_avail is low.
- R2: The register at address 0 holds direction in bit 0, enable in bit 7, threshold in bits 14:8 and chip select in bits 26:24, and all other bits read zero. The register at address 1 holds the byte count in bits 13:0. Control is at address 2 (bit 0) and status is at address 3.
- R3: Writing control with bit 0 set while idle starts a run and loads the remaining count from address 1, but only when enable is 1 and threshold is at most DEPTH. Otherwise control stays 0.
- R4: While a run is active, writes to address 0, writes to address 1 and writes of a set bit 0 to control are all ignored.
- R5: nand_rd_req is high only while a run is active, the remaining count is nonzero, the FIFO holds fewer than DEPTH bytes and nand_ready is high. Each such cycle consumes nand_data into the FIFO and lowers the remaining count by one, so exactly count bytes are taken per run.
- R6: Status bits 13:0 give the remaining count and bits 30:24 give the FIFO fill in bytes. All other status bits read zero.
- R7: A host read with at least four bytes buffered pops four bytes and returns them little-endian, with the oldest byte in bits 7:0. host_underflow stays low.
- R8: A host read with fewer than four bytes buffered returns the buffered bytes little-endian, with zero in the missing upper bytes. It pops them and raises host_underflow in that cycle.
- R9: host_avail is high when a run is active and either the fill is at least the threshold, or the remaining count is zero and the fill is nonzero.
- R10: Control returns to 0 by itself one cycle after the remaining count and the fill are both zero.
- R11: Writing control with bit 0 clear stops a run. The FIFO is emptied, the remaining count goes to zero, and a later run starts clean. Writing 0 to address 0 while idle clears that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| nand_ready | input | 1 | Flash ready for a data byte |
| nand_data | input | 8 | Flash data byte, taken in a cycle with nand_rd_req high |
| nand_rd_req | output | 1 | Byte read strobe towards the flash |
| host_rd | input | 1 | Host word read strobe |
| host_rdata | output | 32 | Oldest buffered bytes, little-endian |
| host_underflow | output | 1 | Host read with fewer than four bytes buffered |
| host_avail | output | 1 | Threshold reached, or the final bytes are waiting |

## Verification
The bench builds the engine with a 16-byte FIFO and the default 14-bit count. With this size the FIFO-full stall, threshold values up to the legal maximum, and the refused start just above it all come up within a few dozen cycles. The bench sweeps every count from 1 to 20 against four flash-ready patterns and two thresholds. This covers every ending remainder (0 to 3 bytes left for the final short read) with both steady and gappy fetching.

// File: rtl/pfe_pkg.sv
package pfe_pkg;
  localparam logic [1:0] A_CFG1 = 2'd0;
  localparam logic [1:0] A_CFG2 = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  localparam int DIR_BIT   = 0;
  localparam int EN_BIT    = 7;
  localparam int THR_LSB   = 8;
  localparam int THR_W     = 7;
  localparam int CS_LSB    = 24;
  localparam int CS_W      = 3;
  localparam int FILLF_LSB = 24;
  localparam int FILLF_W   = 7;

  typedef struct packed {
    logic [CS_W-1:0]  cs;
    logic [THR_W-1:0] thr;
    logic             en;
    logic             dir;
  } cfg1_t;

  function automatic logic [31:0] pack_cfg1(input cfg1_t c);
    logic [31:0] w;
    w = '0;
    w[DIR_BIT]           = c.dir;
    w[EN_BIT]            = c.en;
    w[THR_LSB +: THR_W]  = c.thr;
    w[CS_LSB +: CS_W]    = c.cs;
    return w;
  endfunction

  function automatic cfg1_t unpack_cfg1(input logic [31:0] w);
    cfg1_t c;
    c.dir = w[DIR_BIT];
    c.en  = w[EN_BIT];
    c.thr = w[THR_LSB +: THR_W];
    c.cs  = w[CS_LSB +: CS_W];
    return c;
  endfunction

  // bytes removed by one host read: four, or whatever is left
  function automatic logic [2:0] take_count(input logic rd, input logic [31:0] fill);
    if (!rd)            return 3'd0;
    else if (fill >= 4) return 3'd4;
    else                return fill[2:0];
  endfunction
endpackage

// File: rtl/pfe_regs.sv
module pfe_regs
  import pfe_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 14,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [FILL_W-1:0] fill,
  input  logic              byte_taken,
  output logic [31:0]       reg_rdata,
  output logic              active,
  output logic [CNT_W-1:0]  remaining,
  output logic [THR_W-1:0]  thr,
  output logic              stop
);
  cfg1_t            cfg1_q;
  logic [CNT_W-1:0] cnt_cfg;
  logic [CNT_W-1:0] rem_q;
  logic             act_q;
  logic             wr_cfg1, wr_cfg2, start, drained;

  assign wr_cfg1 = reg_wr && (reg_addr == A_CFG1) && !act_q;
  assign wr_cfg2 = reg_wr && (reg_addr == A_CFG2) && !act_q;
  assign start   = reg_wr && (reg_addr == A_CTRL) && reg_wdata[0] && !act_q &&
                   cfg1_q.en && (32'(cfg1_q.thr) <= DEPTH);
  assign stop    = reg_wr && (reg_addr == A_CTRL) && !reg_wdata[0] && act_q;
  assign drained = act_q && (rem_q == '0) && (fill == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg1_q  <= '0;
      cnt_cfg <= '0;
      rem_q   <= '0;
      act_q   <= 1'b0;
    end else begin
      if (wr_cfg1) cfg1_q  <= unpack_cfg1(reg_wdata);
      if (wr_cfg2) cnt_cfg <= reg_wdata[CNT_W-1:0];
      if (start) begin
        act_q <= 1'b1;
        rem_q <= cnt_cfg;
      end else if (stop) begin
        act_q <= 1'b0;
        rem_q <= '0;
      end else begin
        if (drained)    act_q <= 1'b0;
        if (byte_taken) rem_q <= rem_q - 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CFG1: reg_rdata = pack_cfg1(cfg1_q);
      A_CFG2: reg_rdata[CNT_W-1:0] = cnt_cfg;
      A_CTRL: reg_rdata[0] = act_q;
      A_STAT: begin
        reg_rdata[CNT_W-1:0] = rem_q;
        reg_rdata[FILLF_LSB +: FILLF_W] = FILLF_W'(fill);
      end
      default: reg_rdata = '0;
    endcase
  end

  assign active    = act_q;
  assign remaining = rem_q;
  assign thr       = cfg1_q.thr;

  assert_clear_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> $past(stop || ((rem_q == '0) && (fill == '0))));
  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_taken && !stop) |=> (rem_q == $past(rem_q) - 1'b1));
  assert_busy_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && reg_wr && (reg_addr == A_CFG2)) |=> $stable(cnt_cfg));
  assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (act_q && (rem_q == $past(cnt_cfg))));
endmodule

// File: rtl/pfe_fetch.sv
module pfe_fetch #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 14,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              active,
  input  logic [CNT_W-1:0]  remaining,
  input  logic [FILL_W-1:0] fill,
  input  logic              nand_ready,
  output logic              nand_rd_req
);
  logic room;
  assign room        = 32'(fill) < DEPTH;
  assign nand_rd_req = active && (remaining != '0) && room && nand_ready;
endmodule

// File: rtl/pfe_fifo.sv
module pfe_fifo
  import pfe_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [7:0]        push_byte,
  input  logic              pop_rd,
  output logic [31:0]       word,
  output logic              underflow,
  output logic [FILL_W-1:0] fill
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [FILL_W-1:0] fill_q;
  logic [2:0]       npop;

  assign npop      = take_count(pop_rd, 32'(fill_q));
  assign underflow = pop_rd && (32'(fill_q) < 4);
  assign fill      = fill_q;

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign word[8*k +: 8] = (32'(fill_q) > k) ? mem[rd_ptr + PTR_W'(k)] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill_q <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      rd_ptr <= rd_ptr + PTR_W'(npop);
      fill_q <= fill_q + FILL_W'(push) - FILL_W'(npop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= push_byte;
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (32'(fill_q) < DEPTH));
  assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fill_q) <= DEPTH);
  assert_word_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_rd && (32'(fill_q) >= 4) && !flush) |=>
      (fill_q == FILL_W'($past(fill_q) + FILL_W'($past(push)) - FILL_W'(4))));
  assert_short_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_rd && (32'(fill_q) < 4) && !push && !flush) |=> (fill_q == '0));
endmodule

// File: rtl/nand_prefetch.sv
module nand_prefetch
  import pfe_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 14,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        nand_ready,
  input  logic [7:0]  nand_data,
  output logic        nand_rd_req,
  input  logic        host_rd,
  output logic [31:0] host_rdata,
  output logic        host_underflow,
  output logic        host_avail
);
  logic              active, stop;
  logic [CNT_W-1:0]  remaining;
  logic [THR_W-1:0]  thr;
  logic [FILL_W-1:0] fill;

  pfe_regs #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .fill(fill), .byte_taken(nand_rd_req),
    .reg_rdata(reg_rdata), .active(active), .remaining(remaining),
    .thr(thr), .stop(stop)
  );

  pfe_fetch #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fetch (
    .active(active), .remaining(remaining), .fill(fill),
    .nand_ready(nand_ready), .nand_rd_req(nand_rd_req)
  );

  pfe_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(stop), .push(nand_rd_req),
    .push_byte(nand_data), .pop_rd(host_rd), .word(host_rdata),
    .underflow(host_underflow), .fill(fill)
  );

  assign host_avail = active &&
                      ((32'(fill) >= 32'(thr)) || ((remaining == '0) && (fill != '0)));

  assert_req_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nand_rd_req |-> (nand_ready && active));
endmodule

// File: tb/tb_nand_prefetch.sv
module tb_nand_prefetch;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        nand_ready = 1'b1;
  logic [7:0]  nand_data;
  logic        nand_rd_req;
  logic        host_rd = 1'b0;
  logic [31:0] host_rdata;
  logic        host_underflow;
  logic        host_avail;

  int errors = 0, checks = 0, nidx = 0, rmode = 0, rcyc = 0, tcyc = 0;

  always #5 clk = ~clk;

  nand_prefetch #(.DEPTH(DEPTH)) dut (.*);

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction
  assign nand_data = pat(nidx);

  always @(posedge clk) if (nand_rd_req) nidx <= nidx + 1;

  always @(negedge clk) begin
    rcyc++;
    nand_ready = (rmode == 0) || ((rcyc % rmode) != 0);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    tcyc++;
    if (tcyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog R10: actual cycles=%0d expected run end", tcyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic hread(output logic [31:0] d, output logic uf);
    @(negedge clk); host_rd = 1'b1; #1 d = host_rdata; uf = host_underflow;
    @(negedge clk); host_rd = 1'b0;
  endtask

  function automatic logic [31:0] exp_word(input int base, input int off, input int cnt);
    logic [31:0] w = '0;
    for (int k = 0; k < cnt; k++) w[8*k +: 8] = pat(base + off + k);
    return w;
  endfunction

  task automatic drain(input int base, input int off, input int n);
    int got = off, guard = 0;
    logic [31:0] s, d;
    logic uf;
    while (got < n && guard < 3000) begin
      rd(2'd3, s);
      if (s[30:24] >= 4) begin
        hread(d, uf);
        chk("R7 word data", d, exp_word(base, got, 4));
        chk("R7 no underflow", 32'(uf), 0);
        got += 4;
      end else if (s[13:0] == 0 && s[30:24] != 0) begin
        hread(d, uf);
        chk("R8 short word data", d, exp_word(base, got, int'(s[30:24])));
        chk("R8 underflow flag", 32'(uf), 1);
        got += int'(s[30:24]);
      end else @(negedge clk);
      guard++;
    end
    chk("R5 all bytes delivered", got, n);
  endtask

  task automatic do_run(input int n, input int th);
    logic [31:0] d;
    int base;
    wr(2'd0, 32'(th << 8) | 32'h80);
    wr(2'd1, 32'(n));
    base = nidx;
    wr(2'd2, 1);
    drain(base, 0, n);
    @(negedge clk); @(negedge clk);
    rd(2'd2, d);
    chk("R10 control self-clears", d, 0);
    chk("R5 exact byte count fetched", nidx - base, n);
  endtask

  initial begin
    logic [31:0] d;
    logic uf;
    int base, bad;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, d); chk("R1 config1 reset", d, 0);
    rd(2'd1, d); chk("R1 config2 reset", d, 0);
    rd(2'd2, d); chk("R1 control reset", d, 0);
    rd(2'd3, d); chk("R1 status reset", d, 0);
    chk("R1 no request", 32'(nand_rd_req), 0);
    chk("R1 avail low", 32'(host_avail), 0);

    // R2 field layout and masking
    wr(2'd0, 32'h0500_0881); rd(2'd0, d); chk("R2 config1 fields", d, 32'h0500_0881);
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d); chk("R2 config1 mask", d, 32'h0700_7F81);
    wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); chk("R2 config2 mask", d, 32'h0000_3FFF);

    // R3 refused starts
    wr(2'd1, 40);
    wr(2'd0, 32'h0000_1180); wr(2'd2, 1); rd(2'd2, d); chk("R3 threshold above depth refused", d, 0);
    wr(2'd0, 32'h0000_0800); wr(2'd2, 1); rd(2'd2, d); chk("R3 disabled start refused", d, 0);
    wr(2'd0, 32'h0000_1080); wr(2'd2, 1); rd(2'd2, d); chk("R3 threshold equal depth accepted", d, 1);
    wr(2'd2, 0);

    // main run: full stall, busy guard, then drain
    wr(2'd0, 32'h0000_0880);
    base = nidx;
    wr(2'd2, 1);
    rd(2'd2, d); chk("R3 start accepted", d, 1);
    repeat (30) @(negedge clk);
    rd(2'd3, d); chk("R6 status full stall", d, (32'd16 << 24) | 32'd24);
    #1 chk("R5 no request when full", 32'(nand_rd_req), 0);
    chk("R9 avail above threshold", 32'(host_avail), 1);
    wr(2'd1, 99);            rd(2'd1, d); chk("R4 config2 locked", d, 40);
    wr(2'd0, 0);             rd(2'd0, d); chk("R4 config1 locked", d, 32'h0880);
    wr(2'd2, 1);             rd(2'd3, d); chk("R4 restart ignored", d, (32'd16 << 24) | 32'd24);
    hread(d, uf);
    chk("R7 first word little-endian", d, exp_word(base, 0, 4));
    chk("R7 first word no underflow", 32'(uf), 0);
    drain(base, 4, 40);
    @(negedge clk); @(negedge clk);
    rd(2'd2, d); chk("R10 idle after run", d, 0);

    // short final read
    wr(2'd1, 6);
    base = nidx;
    wr(2'd2, 1);
    repeat (10) @(negedge clk);
    rd(2'd3, d); chk("R6 six bytes buffered", d, 32'd6 << 24);
    chk("R9 avail on final bytes below threshold", 32'(host_avail), 1);
    hread(d, uf); chk("R7 word before tail", d, exp_word(base, 0, 4));
    hread(d, uf);
    chk("R8 tail zero padded", d, exp_word(base, 4, 2));
    chk("R8 tail underflow", 32'(uf), 1);
    rd(2'd3, d); chk("R8 tail popped", d, 0);

    // threshold tracking with gappy ready
    wr(2'd0, 32'h0000_0C80);
    wr(2'd1, 20);
    rmode = 4;
    base = nidx;
    wr(2'd2, 1);
    bad = 0;
    for (int c = 0; c < 25; c++) begin
      @(negedge clk);
      rd(2'd3, d);
      if (host_avail !== ((d[30:24] >= 12) || (d[13:0] == 0 && d[30:24] != 0))) bad++;
    end
    chk("R9 avail follows threshold", bad, 0);
    drain(base, 0, 20);
    rmode = 0;
    @(negedge clk); @(negedge clk);

    // stop mid run
    wr(2'd0, 32'h0000_0880);
    wr(2'd1, 30);
    wr(2'd2, 1);
    repeat (5) @(negedge clk);
    wr(2'd2, 0);
    rd(2'd3, d); chk("R11 status cleared by stop", d, 0);
    rd(2'd2, d); chk("R11 control cleared by stop", d, 0);
    #1 chk("R11 no request after stop", 32'(nand_rd_req), 0);
    chk("R11 avail low after stop", 32'(host_avail), 0);
    wr(2'd0, 0); rd(2'd0, d); chk("R11 config1 cleared", d, 0);
    do_run(9, 4);

    // sweep
    begin
      int modes[4] = '{0, 2, 3, 5};
      foreach (modes[m]) begin
        rmode = modes[m];
        for (int n = 1; n <= 20; n++) do_run(n, (n % 2) ? 4 : 16);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule